// File: doc/BRIEF.md
# Ring Qualification Integrator

This block decides whether a burst of ringing on a telephone line is genuine. Its input is the output of a threshold comparator that sits after the line's rectifier and attenuator. That comparator output is already a logic level, but it is not aligned to the system clock. The block measures how much of the time the level is high by integrating it. A counter steps up at a fast rate while the level is high and steps down at half that rate while the level is low. A ring is declared present once the counter reaches an upper threshold. It is withdrawn only when the counter falls back to a lower threshold.

Both step rates are clock enables that the block derives from the system clock through its own parameterised dividers. The default rates are 800 Hz up and 400 Hz down, and the default thresholds are 48 and 32. With these defaults, a level held high from an empty count qualifies in about 60 ms, and a level held low from a full count disqualifies in about 40 ms.

The result is an active-low ring indication. A single-cycle pulse marks each change of state, so that a controller can treat the change as an event.

Top module: `ringq_detect`

## Requirements
- R1: The comparator level passes through a two-stage synchroniser. A change at `cmp_in` can alter the count no earlier than the third rising edge after it is sampled.
- R2: The up step enable fires for one cycle every CLK_HZ/UP_HZ cycles, and the down step enable fires for one cycle every CLK_HZ/DOWN_HZ cycles. Both dividers run freely from reset.
- R3: While the synchronised level is 1, each up step enable raises the count by one. The count stops at QUAL_LEVEL (default 48) and never wraps.
- R4: While the synchronised level is 0, each down step enable lowers the count by one. The count stops at 0 and never wraps.
- R5: When the count reaches QUAL_LEVEL, `ring_det_n` goes to 0 on the same clock edge that updates the count.
- R6: While a ring is qualified, `ring_det_n` returns to 1 on the edge at which the count falls to DISQUAL_LEVEL (default 32).
- R7: `qual_evt` is high for exactly the one cycle in which `ring_det_n` falls, and `disq_evt` is high for exactly the one cycle in which it rises. The two are never high together.
- R8: A synchronous reset clears the count and both synchroniser stages, sets `ring_det_n` to 1, and clears both event outputs.
- R9: While the count lies strictly between the two thresholds, `ring_det_n` keeps its previous value, whichever direction the count is moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator level, 1 = above threshold |
| ring_det_n | output | 1 | Ring qualified, active low |
| qual_evt | output | 1 | One-cycle pulse when the ring becomes qualified |
| disq_evt | output | 1 | One-cycle pulse when the ring becomes disqualified |

## Verification
The hardest situation to reach from the ports is a count parked strictly inside the hysteresis band, with either value of the output. The bench reaches it through timing alone. It holds the level high or low for a chosen multiple of the step periods: from a full count it drops about eight steps, and from an empty count it climbs about forty. It then reverses direction and checks that the output has not moved. Duty-cycle patterns of 25 % and 50 % show that the asymmetric rates give a net drift downward in the first case and upward in the second.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // Number of system clocks per step enable; never below one.
  function automatic int tick_ratio(input int clk_hz, input int rate_hz);
    int r;
    r = clk_hz / rate_hz;
    return (r < 1) ? 1 : r;
  endfunction

  // Next integrator value with saturation at 0 and at top.
  function automatic int integ_step(input int cur, input bit lvl,
                                    input bit up_t, input bit dn_t,
                                    input int top);
    int nx;
    nx = cur;
    if (lvl && up_t && cur < top) nx = cur + 1;
    else if (!lvl && dn_t && cur > 0) nx = cur - 1;
    return nx;
  endfunction

  // Hysteresis decision on the updated count.
  function automatic bit hyst_next(input bit q, input int cnt,
                                   input int on_lvl, input int off_lvl);
    bit r;
    r = q;
    if (!q && cnt >= on_lvl) r = 1'b1;
    else if (q && cnt <= off_lvl) r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/ringq_sync.sv
module ringq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ringq_tick.sv
module ringq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/ringq_integ.sv
module ringq_integ
  import ringq_pkg::*;
#(
  parameter int QUAL  = 48,
  parameter int DISQ  = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic          up_tick,
  input  logic          dn_tick,
  output logic [CW-1:0] count,
  output logic          qualified,
  output logic          qual_evt,
  output logic          disq_evt
);
  int   cnt_nx;
  logic q_nx;

  always_comb begin
    cnt_nx = integ_step(int'(count), lvl, up_tick, dn_tick, QUAL);
    q_nx   = hyst_next(qualified, cnt_nx, QUAL, DISQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      qualified <= 1'b0;
      qual_evt  <= 1'b0;
      disq_evt  <= 1'b0;
    end else begin
      count     <= CW'(cnt_nx);
      qualified <= q_nx;
      qual_evt  <= q_nx & ~qualified;
      disq_evt  <= ~q_nx & qualified;
    end
  end
endmodule

// File: rtl/ringq_detect.sv
module ringq_detect
  import ringq_pkg::*;
#(
  parameter int CLK_HZ        = 1000000,
  parameter int UP_HZ         = 800,
  parameter int DOWN_HZ       = 400,
  parameter int QUAL_LEVEL    = 48,
  parameter int DISQUAL_LEVEL = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic ring_det_n,
  output logic qual_evt,
  output logic disq_evt
);
  localparam int UP_DIV = tick_ratio(CLK_HZ, UP_HZ);
  localparam int DN_DIV = tick_ratio(CLK_HZ, DOWN_HZ);
  localparam int CNT_W  = $clog2(QUAL_LEVEL + 1);

  // Named internal events, visible to the bound checker.
  logic             lvl_s;
  logic             up_tick;
  logic             dn_tick;
  logic [CNT_W-1:0] count;
  logic             qualified;

  ringq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (cmp_in), .dout (lvl_s)
  );

  ringq_tick #(.DIV(UP_DIV)) u_up_div (
    .clk (clk), .rst (rst), .tick (up_tick)
  );

  ringq_tick #(.DIV(DN_DIV)) u_dn_div (
    .clk (clk), .rst (rst), .tick (dn_tick)
  );

  ringq_integ #(
    .QUAL (QUAL_LEVEL), .DISQ (DISQUAL_LEVEL), .CW (CNT_W)
  ) u_integ (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl_s),
    .up_tick   (up_tick),
    .dn_tick   (dn_tick),
    .count     (count),
    .qualified (qualified),
    .qual_evt  (qual_evt),
    .disq_evt  (disq_evt)
  );

  assign ring_det_n = ~qualified;
endmodule

// File: rtl/ringq_detect_chk.sv
module ringq_detect_chk #(
  parameter int QUAL   = 48,
  parameter int DISQ   = 32,
  parameter int CW     = 6,
  parameter int UP_DIV = 2,
  parameter int DN_DIV = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          lvl_s,
  input logic          up_tick,
  input logic          dn_tick,
  input logic [CW-1:0] count,
  input logic          ring_det_n,
  input logic          qual_evt,
  input logic          disq_evt
);
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= QUAL); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (lvl_s && up_tick && int'(count) < QUAL) |=> int'(count) == int'($past(count)) + 1); // R3

  AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!lvl_s && dn_tick && count != '0) |=> int'(count) == int'($past(count)) - 1); // R4

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(lvl_s && up_tick) && !(!lvl_s && dn_tick) |=> $stable(count)); // R4

  AST_UP_TICK_SHORT: assert property (@(posedge clk) disable iff (rst)
    (UP_DIV > 1 && up_tick) |=> !up_tick); // R2

  AST_DN_TICK_SHORT: assert property (@(posedge clk) disable iff (rst)
    (DN_DIV > 1 && dn_tick) |=> !dn_tick); // R2

  AST_QUAL_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    $fell(ring_det_n) |-> int'(count) == QUAL); // R5

  AST_DISQ_AT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    $rose(ring_det_n) |-> int'(count) == DISQ); // R6

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(qual_evt && disq_evt)); // R7

  AST_QUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    qual_evt == $fell(ring_det_n)); // R7

  AST_DISQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    disq_evt == $rose(ring_det_n)); // R7

  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (int'(count) > DISQ && int'(count) < QUAL) |-> $stable(ring_det_n)); // R9
endmodule

bind ringq_detect ringq_detect_chk #(
  .QUAL (QUAL_LEVEL), .DISQ (DISQUAL_LEVEL), .CW (CNT_W),
  .UP_DIV (UP_DIV), .DN_DIV (DN_DIV)
) u_chk (
  .clk (clk), .rst (rst), .lvl_s (lvl_s), .up_tick (up_tick),
  .dn_tick (dn_tick), .count (count), .ring_det_n (ring_det_n),
  .qual_evt (qual_evt), .disq_evt (disq_evt)
);

// File: tb/ringq_detect_test.sv
module ringq_detect_test;
  localparam int PERIOD = 10;
  localparam int CLKF   = 96000;
  localparam int UPD    = CLKF / 800;   // 120 clocks per up step
  localparam int DND    = CLKF / 400;   // 240 clocks per down step
  localparam int TOP    = 48;
  localparam int LOW    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic ring_det_n, qual_evt, disq_evt;

  int checks = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  ringq_detect #(.CLK_HZ(CLKF)) uut (
    .clk (clk), .rst (rst), .cmp_in (cmp_in),
    .ring_det_n (ring_det_n), .qual_evt (qual_evt), .disq_evt (disq_evt)
  );

  // Behavioural reference: delay line, free-running step timers, saturating count.
  bit m_line[$];
  int m_up_ph, m_dn_ph, m_cnt;
  bit m_q, m_qe, m_de;

  always @(posedge clk) begin
    bit lvl, ut, dt;
    if (rst) begin
      m_line = '{0, 0};
      m_up_ph = 0; m_dn_ph = 0; m_cnt = 0;
      m_q = 0; m_qe = 0; m_de = 0;
    end else begin
      lvl = m_line[0];
      ut = (m_up_ph == UPD - 1);
      dt = (m_dn_ph == DND - 1);
      m_up_ph = ut ? 0 : m_up_ph + 1;
      m_dn_ph = dt ? 0 : m_dn_ph + 1;
      void'(m_line.pop_front());
      m_line.push_back(cmp_in);
      if (lvl && ut) m_cnt = (m_cnt < TOP) ? m_cnt + 1 : TOP;
      if (!lvl && dt) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      m_qe = 0; m_de = 0;
      if (!m_q && m_cnt == TOP) begin m_q = 1; m_qe = 1; end
      else if (m_q && m_cnt <= LOW) begin m_q = 0; m_de = 1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference (R1 R2 R3 R4 R5 R6 R7).
  always @(negedge clk) begin
    if (!rst) begin
      check(ring_det_n == !m_q, "R1 R2 R5 R6 ring_det_n vs model", ring_det_n, !m_q);
      check(qual_evt == m_qe, "R7 qual_evt vs model", qual_evt, m_qe);
      check(disq_evt == m_de, "R7 disq_evt vs model", disq_evt, m_de);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_out(input logic target, input int limit, output int n);
    n = 0;
    while (ring_det_n !== target && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    cycles(5);
    check(ring_det_n == 1'b1, "R8 reset output", ring_det_n, 1);
    check(qual_evt == 0 && disq_evt == 0, "R8 reset events", qual_evt | disq_evt, 0);
    rst = 1'b0;

    // Qualify from an empty count.
    cmp_in = 1'b1;
    wait_out(1'b0, 20000, n);
    check(n >= 47*UPD && n <= 48*UPD + 4, "R5 R2 qualify time", n, 48*UPD);

    // Long high: count must stay at the ceiling.
    cycles(3000);
    check(ring_det_n == 1'b0, "R3 saturated high", ring_det_n, 0);
    cmp_in = 1'b0;
    wait_out(1'b1, 20000, n);
    check(n >= 15*DND && n <= 16*DND + 4, "R6 R3 disqualify time from full", n, 16*DND);

    // Long low: count must stop at zero.
    cycles(10000);
    cmp_in = 1'b1;
    wait_out(1'b0, 20000, n);
    check(n >= 47*UPD && n <= 48*UPD + 4, "R4 requalify after floor", n, 48*UPD);

    // Inside the band going down while qualified.
    cmp_in = 1'b0;
    cycles(8*DND);
    check(ring_det_n == 1'b0, "R9 qualified held in band", ring_det_n, 0);
    cmp_in = 1'b1;
    cycles(2000);
    check(ring_det_n == 1'b0, "R9 qualified held on return", ring_det_n, 0);
    cmp_in = 1'b0;
    cycles(12000);
    check(ring_det_n == 1'b1, "R6 disqualified after long low", ring_det_n, 1);

    // Inside the band going up while not qualified.
    cmp_in = 1'b1;
    cycles(40*UPD);
    check(ring_det_n == 1'b1, "R9 unqualified held in band", ring_det_n, 1);
    cmp_in = 1'b0;
    cycles(2000);
    check(ring_det_n == 1'b1, "R9 unqualified held on fall", ring_det_n, 1);
    cycles(12000);

    // 25 % duty: net drift down, never qualifies.
    seen = 0;
    for (int p = 0; p < 30; p++) begin
      cmp_in = 1'b1;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (!ring_det_n) seen = 1; end
      cmp_in = 1'b0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (!ring_det_n) seen = 1; end
    end
    check(!seen, "R3 R4 low duty never qualifies", seen, 0);

    // 50 % duty: net drift up, qualifies.
    for (int p = 0; p < 80; p++) begin
      cmp_in = 1'b1; cycles(200);
      cmp_in = 1'b0; cycles(200);
    end
    check(ring_det_n == 1'b0, "R3 R5 half duty qualifies", ring_det_n, 0);

    // Reset while qualified.
    rst = 1'b1;
    cycles(2);
    check(ring_det_n == 1'b1, "R8 reset mid-run output", ring_det_n, 1);
    check(qual_evt == 0 && disq_evt == 0, "R8 reset mid-run events", qual_evt | disq_evt, 0);
    rst = 1'b0;
    cmp_in = 1'b0;
    cycles(50);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule